// File: doc/BRIEF.md
# Auto-Pointer Message Buffer Port

This block gives a host processor byte access to two link-layer message buffer pairs. Each pair holds a transmit memory and a receive memory of 96 bytes. Neither pair has an address register the host can see. Each pair is reached through one data offset in the channel's register space: offset 6 for pair 0 and offset 7 for pair 1. A host write to that offset stores a byte into the pair's transmit memory. A host read of the same offset returns a byte from the pair's receive memory.

Each pair has one internal pointer that selects the location. Reads and writes share it. The pointer starts at zero, advances after every access, and wraps after the last location. The host cannot read the pointer back, so it must count its own accesses. A clear input per pair returns the pointer to zero, for example when a message is finished or thrown away.

A side port serves the message engine. The engine reads transmit bytes and writes receive bytes by explicit address, without using the host pointer. When the host and the engine touch the same location in the same cycle, the host wins.

Top module: `msgbuf_port`

## Requirements
- R1: After reset both pointers are 0 and `host_rdata` is 0. The first host access to a pair uses location 0.
- R2: A host write (`host_cs`=1, `host_we`=1) to offset 6 stores `host_wdata` into the transmit memory of pair 0, and to offset 7 into pair 1, at that pair's current pointer.
- R3: A host read (`host_cs`=1, `host_re`=1) to offset 6 or 7 returns that pair's receive byte at the current pointer on `host_rdata` one cycle later. `host_rdata` holds its value in every cycle without a host read.
- R4: The pointer rises by one after each host access. Reads and writes move the same pointer.
- R5: After location 95 the pointer wraps to 0.
- R6: `ptr_clr[i]` sets pair i's pointer to 0 in the next cycle. It overrides the advance of an access made in the same cycle, and that access still uses the old pointer.
- R7: An access with `host_cs`=0, or to any offset other than 6 or 7, stores nothing, does not move a pointer and leaves `host_rdata` unchanged.
- R8: The two pairs have separate pointers and memories. An access to one pair does not move the other pair's pointer.
- R9: `eng_tx_data` shows the transmit byte of pair `eng_sel` at `eng_tx_addr` one cycle after the address is applied. It is 0 for addresses 96 and above.
- R10: With `eng_rx_we`=1, `eng_rx_wdata` is stored in the receive memory of pair `eng_sel` at `eng_rx_addr`. A write to address 96 or above is dropped.
- R11: Same-location collisions favour the host. If the host writes the location the engine is reading, the engine receives the new byte. If the host reads the location the engine is writing, the host gets the old byte and the engine write is dropped.
- R12: If `host_we` and `host_re` are both set, only the write happens: `host_rdata` does not change and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host select |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| ptr_clr | input | 2 | Per-pair pointer clear |
| eng_sel | input | 1 | Pair chosen by the engine side port |
| eng_tx_addr | input | 7 | Engine transmit read address |
| eng_tx_data | output | 8 | Engine transmit read byte, one cycle latency |
| eng_rx_we | input | 1 | Engine receive write enable |
| eng_rx_addr | input | 7 | Engine receive write address |
| eng_rx_wdata | input | 8 | Engine receive write byte |

## Verification
The bench runs several access patterns and each one separates a different kind of fault. Runs of host reads over engine-filled receive bytes show whether the order is right and the pointer advances. A mix of host writes after reads, checked through the engine port, shows that reads and writes share one pointer. A full 97-read sweep exposes a bad wrap point. Accesses to wrong offsets, with chip select low, or with a clear in the same cycle catch faulty decode and faulty precedence. Same-cycle collisions on one location and a combined write-and-read strobe confirm that the host wins and that only the write takes effect.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;
    localparam int DATA_W   = 8;
    localparam int DEPTH    = 96;
    localparam int PTR_W    = $clog2(DEPTH);
    localparam int NBUF     = 2;
    localparam int SEL_W    = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int ADDR_W   = 4;
    localparam int BASE_OFS = 6;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef struct packed {
        logic  wr;
        logic  rd;
        byte_t wdata;
    } host_acc_t;

    typedef struct packed {
        logic  we;
        ptr_t  addr;
        byte_t data;
    } eng_wr_t;

    function automatic ptr_t ptr_next(input ptr_t p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic in_range(input ptr_t a);
        return (int'(a) < DEPTH);
    endfunction
endpackage

// File: rtl/msgbuf_ptr.sv
module msgbuf_ptr
    import msgbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output ptr_t ptr
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            ptr <= '0;
        else if (step)
            ptr <= ptr_next(ptr);
    end

    assert_ptr_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == '0));
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && ptr != PTR_W'(DEPTH - 1)) |=> (ptr == $past(ptr) + PTR_W'(1)));
    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && ptr == PTR_W'(DEPTH - 1)) |=> (ptr == '0));
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(ptr));
endmodule

// File: rtl/msgbuf_lane.sv
module msgbuf_lane
    import msgbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_acc_t acc,
    input  logic      clr,
    input  ptr_t      eng_rd_addr,
    input  eng_wr_t   eng_wr,
    output byte_t     rx_at_ptr,
    output byte_t     tx_q
);
    byte_t tx_mem [DEPTH];
    byte_t rx_mem [DEPTH];
    ptr_t  ptr;
    logic  step;
    logic  eng_ok;

    assign step = acc.wr | acc.rd;

    msgbuf_ptr u_ptr (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .step (step),
        .ptr  (ptr)
    );

    // host has priority: a receive write colliding with a host read is dropped
    assign eng_ok = eng_wr.we && in_range(eng_wr.addr) && !(acc.rd && eng_wr.addr == ptr);

    always_ff @(posedge clk) begin
        if (acc.wr)
            tx_mem[ptr] <= acc.wdata;
        if (eng_ok)
            rx_mem[eng_wr.addr] <= eng_wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tx_q <= '0;
        else if (acc.wr && eng_rd_addr == ptr)
            tx_q <= acc.wdata;
        else if (in_range(eng_rd_addr))
            tx_q <= tx_mem[eng_rd_addr];
        else
            tx_q <= '0;
    end

    assign rx_at_ptr = rx_mem[ptr];

    assert_tx_store_R2: assert property (@(posedge clk) disable iff (rst)
        acc.wr |=> (tx_mem[$past(ptr)] == $past(acc.wdata)));
    assert_single_op_R12: assert property (@(posedge clk) disable iff (rst)
        !(acc.wr && acc.rd));
endmodule

// File: rtl/msgbuf_port.sv
module msgbuf_port
    import msgbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [NBUF-1:0]   ptr_clr,
    input  logic [SEL_W-1:0]  eng_sel,
    input  logic [PTR_W-1:0]  eng_tx_addr,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_rx_we,
    input  logic [PTR_W-1:0]  eng_rx_addr,
    input  logic [DATA_W-1:0] eng_rx_wdata
);
    host_acc_t        acc    [NBUF];
    eng_wr_t          ewr    [NBUF];
    byte_t            rx_byte[NBUF];
    byte_t            tx_byte[NBUF];
    logic [NBUF-1:0]  rd_vec;
    logic [SEL_W-1:0] sel_q;

    always_comb begin
        for (int i = 0; i < NBUF; i++) begin
            logic hit;
            hit          = host_cs && (host_addr == ADDR_W'(BASE_OFS + i));
            acc[i].wr    = hit && host_we;
            acc[i].rd    = hit && host_re && !host_we;
            acc[i].wdata = host_wdata;
            rd_vec[i]    = acc[i].rd;
            ewr[i].we    = eng_rx_we && (eng_sel == SEL_W'(i));
            ewr[i].addr  = eng_rx_addr;
            ewr[i].data  = eng_rx_wdata;
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_lane
        msgbuf_lane u_lane (
            .clk         (clk),
            .rst         (rst),
            .acc         (acc[g]),
            .clr         (ptr_clr[g]),
            .eng_rd_addr (eng_tx_addr),
            .eng_wr      (ewr[g]),
            .rx_at_ptr   (rx_byte[g]),
            .tx_q        (tx_byte[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
            sel_q      <= '0;
        end else begin
            sel_q <= eng_sel;
            for (int i = 0; i < NBUF; i++)
                if (acc[i].rd)
                    host_rdata <= rx_byte[i];
        end
    end

    assign eng_tx_data = tx_byte[sel_q];

    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_vec == '0) |=> $stable(host_rdata));
    assert_one_pair_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_vec));
endmodule

// File: tb/sim_msgbuf_port.sv
module sim_msgbuf_port;
    logic       clk = 0;
    logic       rst = 1;
    logic       host_cs = 0, host_we = 0, host_re = 0;
    logic [3:0] host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic [1:0] ptr_clr = 0;
    logic       eng_sel = 0;
    logic [6:0] eng_tx_addr = 0;
    logic [7:0] eng_tx_data;
    logic       eng_rx_we = 0;
    logic [6:0] eng_rx_addr = 0;
    logic [7:0] eng_rx_wdata = 0;

    int total = 0;
    int bad = 0;
    logic [7:0] v;

    always #2.5 clk = ~clk;

    msgbuf_port u0 (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hw(int b, logic [7:0] d);
        @(negedge clk);
        host_cs = 1; host_we = 1; host_addr = 4'(6 + b); host_wdata = d;
        @(negedge clk);
        host_cs = 0; host_we = 0;
    endtask

    task automatic hr(int b, output logic [7:0] d);
        @(negedge clk);
        host_cs = 1; host_re = 1; host_addr = 4'(6 + b);
        @(negedge clk);
        d = host_rdata;
        host_cs = 0; host_re = 0;
    endtask

    task automatic er(int b, int a, output logic [7:0] d);
        @(negedge clk);
        eng_sel = b[0]; eng_tx_addr = 7'(a);
        @(negedge clk);
        d = eng_tx_data;
    endtask

    task automatic ew(int b, int a, logic [7:0] d);
        @(negedge clk);
        eng_sel = b[0]; eng_rx_addr = 7'(a); eng_rx_wdata = d; eng_rx_we = 1;
        @(negedge clk);
        eng_rx_we = 0;
    endtask

    task automatic pclr(int b);
        @(negedge clk);
        ptr_clr[b] = 1;
        @(negedge clk);
        ptr_clr = 0;
    endtask

    task automatic t_reset;
        check("R1 reset rdata", host_rdata, 8'h00);
    endtask

    task automatic t_rx_order;
        for (int i = 0; i < 4; i++) ew(0, i, 8'(8'h10 + i));
        for (int i = 0; i < 4; i++) begin
            hr(0, v);
            check("R1/R3/R10 rx order", v, 8'(8'h10 + i));
        end
    endtask

    task automatic t_tx_shared;
        for (int i = 0; i < 3; i++) hw(0, 8'(8'hA0 + i));
        for (int i = 0; i < 3; i++) begin
            er(0, 4 + i, v);
            check("R2/R4 shared pointer", v, 8'(8'hA0 + i));
        end
    endtask

    task automatic t_indep;
        ew(1, 0, 8'h5A); ew(1, 1, 8'h5B);
        hr(1, v); check("R8 pair1 starts at 0", v, 8'h5A);
        hr(1, v); check("R8 pair1 advance", v, 8'h5B);
    endtask

    task automatic t_ignore;
        pclr(0);
        hw(0, 8'h11);
        pclr(0);
        @(negedge clk);
        host_cs = 0; host_we = 1; host_addr = 4'd6; host_wdata = 8'h99;
        @(negedge clk);
        host_cs = 1; host_addr = 4'd5;
        @(negedge clk);
        host_we = 0; host_re = 1;
        @(negedge clk);
        check("R7 rdata unchanged", host_rdata, 8'h5B);
        host_cs = 0; host_re = 0;
        er(0, 0, v); check("R7 no store", v, 8'h11);
        hw(0, 8'h22);
        er(0, 0, v); check("R7 pointer unmoved", v, 8'h22);
    endtask

    task automatic t_clr;
        pclr(0);
        hw(0, 8'h30);
        @(negedge clk);
        ptr_clr[0] = 1; host_cs = 1; host_we = 1; host_addr = 4'd6; host_wdata = 8'h31;
        @(negedge clk);
        ptr_clr = 0; host_cs = 0; host_we = 0;
        hw(0, 8'h32);
        er(0, 0, v); check("R6 clear wins", v, 8'h32);
        er(0, 1, v); check("R6 access uses old pointer", v, 8'h31);
    endtask

    task automatic t_wrap;
        pclr(1);
        for (int i = 0; i < 96; i++) ew(1, i, 8'(i) ^ 8'hA5);
        for (int i = 0; i < 96; i++) begin
            hr(1, v);
            check("R5 sweep", v, 8'(i) ^ 8'hA5);
        end
        hr(1, v); check("R5 wrap to 0", v, 8'hA5);
    endtask

    task automatic t_range;
        er(0, 100, v); check("R9 tx out of range", v, 8'h00);
        ew(0, 4, 8'h44);
        ew(0, 100, 8'hEE);
        pclr(0);
        for (int i = 0; i < 5; i++) hr(0, v);
        check("R10 out of range write dropped", v, 8'h44);
    endtask

    task automatic t_collide;
        pclr(0);
        @(negedge clk);
        host_cs = 1; host_we = 1; host_addr = 4'd6; host_wdata = 8'h77;
        eng_sel = 0; eng_tx_addr = 7'd0;
        @(negedge clk);
        host_cs = 0; host_we = 0;
        check("R11 engine sees host byte", eng_tx_data, 8'h77);
        ew(0, 1, 8'h31);
        pclr(0);
        hr(0, v);
        @(negedge clk);
        host_cs = 1; host_re = 1; host_addr = 4'd6;
        eng_sel = 0; eng_rx_addr = 7'd1; eng_rx_wdata = 8'hEE; eng_rx_we = 1;
        @(negedge clk);
        host_cs = 0; host_re = 0; eng_rx_we = 0;
        check("R11 host reads old byte", host_rdata, 8'h31);
        pclr(0);
        hr(0, v); hr(0, v);
        check("R11 engine write dropped", v, 8'h31);
    endtask

    task automatic t_both;
        pclr(0);
        ew(0, 0, 8'h40);
        @(negedge clk);
        host_cs = 1; host_we = 1; host_re = 1; host_addr = 4'd6; host_wdata = 8'h5C;
        @(negedge clk);
        host_cs = 0; host_we = 0; host_re = 0;
        check("R12 no read", host_rdata, 8'h31);
        er(0, 0, v); check("R12 write done", v, 8'h5C);
        hw(0, 8'h5D);
        er(0, 1, v); check("R12 single advance", v, 8'h5D);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_rx_order();
        t_tx_shared();
        t_indep();
        t_ignore();
        t_clr();
        t_wrap();
        t_range();
        t_collide();
        t_both();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule